// File: doc/BRIEF.md
# Counter Control Register Frame

This block is the software-facing control window of a scaled system counter. It sits on an APB bus and holds the configuration that the counter datapath consumes: a run enable, a halt-on-debug enable, a scaling enable, two 32-bit fixed-point increment values (one for each clock source), an error-interrupt enable, an enable for the bus error response and a bit that unlocks the increment values while the counter runs. The 64-bit count itself lives in the datapath. The frame reads it back as two 32-bit words and hands writes to the datapath as one-cycle load strobes for each half.

Every transfer is checked in its access phase. A transfer whose protection attribute differs from the attribute of the frame is a security mismatch. A transfer whose word index lies outside the implemented registers is a decode miss. Either event sets a sticky pending flag, which raises the error interrupt when that interrupt is enabled. Only a security mismatch can produce a bus error response, and only while that response is enabled. Transfers always complete without wait states.

Top module: `ctrl_frame`

Register word offsets: 0x00 control, 0x04 status, 0x08 pending, 0x0C increment for clock 0, 0x10 increment for clock 1, 0x14 count bits 31:0, 0x18 count bits 63:32.

## Requirements
- R1: After reset the control word reads 0, the pending word reads 0, `err_irq_o` and `pslverr` are 0, and the increment registers read `INC0_RST` (default 0x01000000) and `INC1_RST` (default 0x00800000).
- R2: The control word at 0x00 is read/write in bits 5:0: bit 0 run enable, bit 1 halt-on-debug enable, bit 2 scaling enable, bit 3 error-interrupt enable, bit 4 bus-error-response enable, bit 5 increment-unlock. Bits 31:6 read 0. Bits 0 to 2 drive `cnt_en_o`, `halt_dbg_en_o` and `scale_en_o`.
- R3: The status word at 0x04 is read-only: bit 0 `halted_i`, bits 2:1 `clk_sel_i`, bit 3 scaling implemented (`HAS_SCALE`), bit 4 clock switching implemented (`HAS_CLKSW`). Writes to it have no effect.
- R4: A read at 0x14 returns `cnt_now_i[31:0]` and a read at 0x18 returns `cnt_now_i[63:32]`. A write at 0x14 or 0x18 asserts `cnt_load_lo_o` or `cnt_load_hi_o` during its access phase, with the written word on `cnt_load_data_o`.
- R5: A write to an increment register (0x0C or 0x10) takes effect only when run enable is 0 or increment-unlock is 1. Otherwise the register keeps its value and the transfer completes without a bus error.
- R6: A transfer whose `pprot_ns` differs from `FRAME_NS` (default 0) is a security mismatch: a write is dropped, a read returns 0, and the pending flag is set.
- R7: A transfer at a word index of 7 or more (byte offset 0x1C and up) is a decode miss: it reads 0, writes nothing, sets the pending flag and gives no bus error.
- R8: `pslverr` is 1 only in the access phase of a security-mismatched transfer while control bit 4 is 1.
- R9: Bit 0 of the pending word at 0x08 holds the pending flag. Writing 1 to that bit clears it, and writing 0 leaves it unchanged. `err_irq_o` equals the pending flag ANDed with control bit 3.
- R10: `pready` is always 1, so every transfer ends in its first access cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write |
| paddr | input | ADDR_W | APB byte address within the frame |
| pwdata | input | 32 | APB write data |
| pprot_ns | input | 1 | Protection attribute of the transfer, 1 = non-secure |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| pslverr | output | 1 | APB error response |
| halted_i | input | 1 | Counter is halted by debug |
| clk_sel_i | input | 2 | Current clock-select code |
| cnt_now_i | input | 64 | Current count from the datapath |
| cnt_en_o | output | 1 | Run enable |
| halt_dbg_en_o | output | 1 | Halt-on-debug enable |
| scale_en_o | output | 1 | Scaling enable |
| inc0_o | output | 32 | Increment for clock 0 (8.24 fixed point) |
| inc1_o | output | 32 | Increment for clock 1 (8.24 fixed point) |
| cnt_load_lo_o | output | 1 | Load strobe for count bits 31:0 |
| cnt_load_hi_o | output | 1 | Load strobe for count bits 63:32 |
| cnt_load_data_o | output | 32 | Word to load into the selected half |
| err_irq_o | output | 1 | Error interrupt |

## Verification
The frame is driven with matched-attribute reads and writes to every register, mismatched-attribute reads and writes, and accesses just beyond the last register. These patterns separate a good transfer from each of the two error causes, and the two causes are told apart by whether `pslverr` rises. Increment writes are tried with the counter stopped, running and locked, and running with the unlock bit set, which tells the lock from the override. The enables for the error response and the interrupt are each turned off while an error is pending, which shows that each gate acts on its own output alone.

// File: rtl/ctrl_frame_pkg.sv
package ctrl_frame_pkg;
   localparam int DATA_W   = 32;
   localparam int NUM_REGS = 7;
   localparam int IDX_CTRL = 0;
   localparam int IDX_STAT = 1;
   localparam int IDX_PEND = 2;
   localparam int IDX_INC0 = 3;
   localparam int IDX_INC1 = 4;
   localparam int IDX_CLO  = 5;
   localparam int IDX_CHI  = 6;
   localparam int NUM_INC  = 2;

   localparam int CTRL_BITS = 6;
   localparam int B_RUN    = 0;
   localparam int B_HALT   = 1;
   localparam int B_SCALE  = 2;
   localparam int B_IRQEN  = 3;
   localparam int B_ERREN  = 4;
   localparam int B_UNLOCK = 5;

   typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/cfr_decode.sv
module cfr_decode
   import ctrl_frame_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter bit FRAME_NS = 1'b0,
   localparam int IDX_W   = ADDR_W - 2
) (
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic              pprot_ns,
   output logic              sec_bad,
   output logic              miss,
   output logic [IDX_W-1:0]  idx,
   output logic              good,
   output logic [NUM_REGS-1:0] wr_sel
);
   logic acc;

   assign acc     = psel & penable;
   assign idx     = paddr[ADDR_W-1:2];
   assign sec_bad = acc & (pprot_ns != FRAME_NS);
   assign miss    = acc & (int'(idx) >= NUM_REGS);
   assign good    = acc & ~sec_bad & ~miss;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
      assign wr_sel[i] = good & pwrite & (int'(idx) == i);
   end
endmodule

// File: rtl/cfr_regs.sv
module cfr_regs
   import ctrl_frame_pkg::*;
#(
   parameter int    IDX_W     = 10,
   parameter bit    HAS_SCALE = 1'b1,
   parameter bit    HAS_CLKSW = 1'b1,
   parameter word_t INC0_RST  = 32'h0100_0000,
   parameter word_t INC1_RST  = 32'h0080_0000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_REGS-1:0]  wr_sel,
   input  logic [IDX_W-1:0]     idx,
   input  logic                 good,
   input  word_t                pwdata,
   input  logic                 pend,
   input  logic                 halted_i,
   input  logic [1:0]           clk_sel_i,
   input  logic [2*DATA_W-1:0]  cnt_now_i,
   output logic [CTRL_BITS-1:0] ctrl_q,
   output word_t                inc_q [NUM_INC],
   output word_t                rdata
);
   localparam logic [CTRL_BITS-1:0] CTRL_MASK =
      HAS_SCALE ? {CTRL_BITS{1'b1}} : ~(CTRL_BITS'(1) << B_SCALE);
   localparam word_t INC_RST [NUM_INC] = '{INC0_RST, INC1_RST};

   logic inc_open;
   word_t stat_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                ctrl_q <= '0;
      else if (wr_sel[IDX_CTRL]) ctrl_q <= pwdata[CTRL_BITS-1:0] & CTRL_MASK;
   end

   assign inc_open = ~ctrl_q[B_RUN] | ctrl_q[B_UNLOCK];

   for (genvar i = 0; i < NUM_INC; i++) begin : g_inc
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                inc_q[i] <= INC_RST[i];
         else if (wr_sel[IDX_INC0 + i] && inc_open) inc_q[i] <= pwdata;
      end
   end

   assign stat_w = {27'd0, HAS_CLKSW, HAS_SCALE, clk_sel_i, halted_i};

   always_comb begin
      rdata = '0;
      if (good) begin
         case (int'(idx))
            IDX_CTRL: rdata = word_t'(ctrl_q);
            IDX_STAT: rdata = stat_w;
            IDX_PEND: rdata = word_t'(pend);
            IDX_INC0: rdata = inc_q[0];
            IDX_INC1: rdata = inc_q[1];
            IDX_CLO:  rdata = cnt_now_i[DATA_W-1:0];
            IDX_CHI:  rdata = cnt_now_i[2*DATA_W-1:DATA_W];
            default:  rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/cfr_err.sv
module cfr_err (
   input  logic clk,
   input  logic rst_n,
   input  logic sec_bad,
   input  logic miss,
   input  logic clr_req,
   input  logic irq_en,
   input  logic resp_en,
   output logic pend_q,
   output logic err_irq,
   output logic slverr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              pend_q <= 1'b0;
      else if (sec_bad | miss) pend_q <= 1'b1;
      else if (clr_req)        pend_q <= 1'b0;
   end

   assign err_irq = pend_q & irq_en;
   assign slverr  = sec_bad & resp_en;
endmodule

// File: rtl/ctrl_frame.sv
module ctrl_frame
   import ctrl_frame_pkg::*;
#(
   parameter int    ADDR_W    = 12,
   parameter bit    FRAME_NS  = 1'b0,
   parameter bit    HAS_SCALE = 1'b1,
   parameter bit    HAS_CLKSW = 1'b1,
   parameter word_t INC0_RST  = 32'h0100_0000,
   parameter word_t INC1_RST  = 32'h0080_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [31:0]       pwdata,
   input  logic              pprot_ns,
   output logic [31:0]       prdata,
   output logic              pready,
   output logic              pslverr,
   input  logic              halted_i,
   input  logic [1:0]        clk_sel_i,
   input  logic [63:0]       cnt_now_i,
   output logic              cnt_en_o,
   output logic              halt_dbg_en_o,
   output logic              scale_en_o,
   output logic [31:0]       inc0_o,
   output logic [31:0]       inc1_o,
   output logic              cnt_load_lo_o,
   output logic              cnt_load_hi_o,
   output logic [31:0]       cnt_load_data_o,
   output logic              err_irq_o
);
   localparam int IDX_W = ADDR_W - 2;

   if (ADDR_W < 5) begin : g_addr_too_narrow
      $error("ctrl_frame: ADDR_W must be at least 5 to cover the register frame");
   end

   logic                 sec_bad, miss, good, pend_q;
   logic [IDX_W-1:0]     idx;
   logic [NUM_REGS-1:0]  wr_sel;
   logic [CTRL_BITS-1:0] ctrl_q;
   word_t                inc_q [NUM_INC];

   cfr_decode #(.ADDR_W(ADDR_W), .FRAME_NS(FRAME_NS)) u_dec (
      .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
      .pprot_ns(pprot_ns), .sec_bad(sec_bad), .miss(miss), .idx(idx),
      .good(good), .wr_sel(wr_sel)
   );

   cfr_regs #(
      .IDX_W(IDX_W), .HAS_SCALE(HAS_SCALE), .HAS_CLKSW(HAS_CLKSW),
      .INC0_RST(INC0_RST), .INC1_RST(INC1_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .idx(idx), .good(good),
      .pwdata(pwdata), .pend(pend_q), .halted_i(halted_i),
      .clk_sel_i(clk_sel_i), .cnt_now_i(cnt_now_i), .ctrl_q(ctrl_q),
      .inc_q(inc_q), .rdata(prdata)
   );

   cfr_err u_err (
      .clk(clk), .rst_n(rst_n), .sec_bad(sec_bad), .miss(miss),
      .clr_req(wr_sel[IDX_PEND] & pwdata[0]),
      .irq_en(ctrl_q[B_IRQEN]), .resp_en(ctrl_q[B_ERREN]),
      .pend_q(pend_q), .err_irq(err_irq_o), .slverr(pslverr)
   );

   assign pready          = 1'b1;
   assign cnt_en_o        = ctrl_q[B_RUN];
   assign halt_dbg_en_o   = ctrl_q[B_HALT];
   assign scale_en_o      = ctrl_q[B_SCALE];
   assign inc0_o          = inc_q[0];
   assign inc1_o          = inc_q[1];
   assign cnt_load_lo_o   = wr_sel[IDX_CLO];
   assign cnt_load_hi_o   = wr_sel[IDX_CHI];
   assign cnt_load_data_o = pwdata;
endmodule

// File: rtl/ctrl_frame_chk.sv
module ctrl_frame_chk #(
   parameter bit FRAME_NS = 1'b0
) (
   input logic        clk,
   input logic        rst_n,
   input logic        psel,
   input logic        penable,
   input logic        pwrite,
   input logic        pprot_ns,
   input logic        pready,
   input logic        pslverr,
   input logic        err_irq_o,
   input logic        pend_q,
   input logic [5:0]  ctrl_q,
   input logic [31:0] inc0_o,
   input logic [31:0] inc1_o,
   input logic        cnt_load_lo_o,
   input logic        cnt_load_hi_o
);
   // R10
   pready_high_chk: assert property (@(posedge clk) disable iff (!rst_n) pready);

   // R8
   slverr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pslverr |-> (psel && penable && (pprot_ns != FRAME_NS)));

   // R6
   mismatch_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && penable && (pprot_ns != FRAME_NS)) |=> pend_q);

   // R9
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_irq_o |-> (pend_q && ctrl_q[3]));

   // R5
   inc0_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(inc0_o) |-> $past(!ctrl_q[0] || ctrl_q[5]));

   // R5
   inc1_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(inc1_o) |-> $past(!ctrl_q[0] || ctrl_q[5]));

   // R4
   load_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_load_lo_o || cnt_load_hi_o) |-> (psel && penable && pwrite && (pprot_ns == FRAME_NS)));
endmodule

bind ctrl_frame ctrl_frame_chk #(.FRAME_NS(FRAME_NS)) u_chk (
   .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
   .pprot_ns(pprot_ns), .pready(pready), .pslverr(pslverr),
   .err_irq_o(err_irq_o), .pend_q(pend_q), .ctrl_q(ctrl_q),
   .inc0_o(inc0_o), .inc1_o(inc1_o),
   .cnt_load_lo_o(cnt_load_lo_o), .cnt_load_hi_o(cnt_load_hi_o)
);

// File: tb/ctrl_frame_test.sv
module ctrl_frame_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0, pprot_ns = 1'b0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        pready, pslverr;
   logic        halted_i = 1'b1;
   logic [1:0]  clk_sel_i = 2'b10;
   logic [63:0] cnt_now_i = 64'h1234_5678_9ABC_DEF0;
   logic        cnt_en_o, halt_dbg_en_o, scale_en_o;
   logic [31:0] inc0_o, inc1_o, cnt_load_data_o;
   logic        cnt_load_lo_o, cnt_load_hi_o, err_irq_o;

   int n_chk = 0;
   int n_bad = 0;

   logic [31:0] g_rd, g_ld;
   logic        g_err, g_rdy, g_lo, g_hi;

   always #10 clk = ~clk;

   ctrl_frame uut (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .pprot_ns(pprot_ns), .prdata(prdata),
      .pready(pready), .pslverr(pslverr), .halted_i(halted_i),
      .clk_sel_i(clk_sel_i), .cnt_now_i(cnt_now_i), .cnt_en_o(cnt_en_o),
      .halt_dbg_en_o(halt_dbg_en_o), .scale_en_o(scale_en_o),
      .inc0_o(inc0_o), .inc1_o(inc1_o), .cnt_load_lo_o(cnt_load_lo_o),
      .cnt_load_hi_o(cnt_load_hi_o), .cnt_load_data_o(cnt_load_data_o),
      .err_irq_o(err_irq_o)
   );

   typedef struct packed {
      logic        wr;
      logic        ns;
      logic [11:0] addr;
      logic [31:0] wdata;
      logic [31:0] exp;
      logic        err;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 22;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 1'b0, 12'h000, 32'h0,         32'h0,         1'b0, 4'd1},  // R1 control reset
      '{1'b0, 1'b0, 12'h00C, 32'h0,         32'h0100_0000, 1'b0, 4'd1},  // R1 inc0 reset
      '{1'b0, 1'b0, 12'h010, 32'h0,         32'h0080_0000, 1'b0, 4'd1},  // R1 inc1 reset
      '{1'b0, 1'b0, 12'h008, 32'h0,         32'h0,         1'b0, 4'd1},  // R1 pending reset
      '{1'b0, 1'b0, 12'h004, 32'h0,         32'h0000_001D, 1'b0, 4'd3},  // R3 status
      '{1'b1, 1'b0, 12'h004, 32'hFFFF_FFFF, 32'h0,         1'b0, 4'd3},  // R3 write ignored
      '{1'b0, 1'b0, 12'h004, 32'h0,         32'h0000_001D, 1'b0, 4'd3},  // R3 unchanged
      '{1'b1, 1'b0, 12'h000, 32'h0000_001E, 32'h0,         1'b0, 4'd2},  // R2
      '{1'b0, 1'b0, 12'h000, 32'h0,         32'h0000_001E, 1'b0, 4'd2},  // R2 readback
      '{1'b1, 1'b0, 12'h00C, 32'hAABB_CCDD, 32'h0,         1'b0, 4'd5},  // R5 stopped: open
      '{1'b0, 1'b0, 12'h00C, 32'h0,         32'hAABB_CCDD, 1'b0, 4'd5},  // R5
      '{1'b1, 1'b0, 12'h000, 32'h0000_001F, 32'h0,         1'b0, 4'd2},  // R2 run
      '{1'b1, 1'b0, 12'h010, 32'h0000_0011, 32'h0,         1'b0, 4'd5},  // R5 locked, no error
      '{1'b0, 1'b0, 12'h010, 32'h0,         32'h0080_0000, 1'b0, 4'd5},  // R5 kept
      '{1'b1, 1'b0, 12'h000, 32'h0000_003F, 32'h0,         1'b0, 4'd2},  // R2 unlock
      '{1'b1, 1'b0, 12'h010, 32'h0000_0011, 32'h0,         1'b0, 4'd5},  // R5 override
      '{1'b0, 1'b0, 12'h010, 32'h0,         32'h0000_0011, 1'b0, 4'd5},  // R5
      '{1'b0, 1'b0, 12'h014, 32'h0,         32'h9ABC_DEF0, 1'b0, 4'd4},  // R4 low
      '{1'b0, 1'b0, 12'h018, 32'h0,         32'h1234_5678, 1'b0, 4'd4},  // R4 high
      '{1'b1, 1'b0, 12'h000, 32'hFFFF_FFFF, 32'h0,         1'b0, 4'd2},  // R2 upper bits
      '{1'b0, 1'b0, 12'h000, 32'h0,         32'h0000_003F, 1'b0, 4'd2},  // R2
      '{1'b0, 1'b1, 12'h000, 32'h0,         32'h0,         1'b1, 4'd6}   // R6 R8 mismatch read
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic xfer(input logic wr, input logic [11:0] a, input logic [31:0] d,
                       input logic ns);
      @(negedge clk);
      psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d; pprot_ns = ns;
      @(negedge clk);
      penable = 1'b1;
      #5;
      g_rd = prdata; g_err = pslverr; g_rdy = pready;
      g_lo = cnt_load_lo_o; g_hi = cnt_load_hi_o; g_ld = cnt_load_data_o;
      @(negedge clk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0; pprot_ns = 1'b0;
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state at the ports
      chk("R1 err_irq", err_irq_o, 0);
      chk("R1 pslverr", pslverr, 0);
      chk("R1 cnt_en", cnt_en_o, 0);
      chk("R1 inc0", inc0_o, 32'h0100_0000);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         xfer(VECS[i].wr, VECS[i].addr, VECS[i].wdata, VECS[i].ns);
         if (!VECS[i].wr)
            chk($sformatf("R%0d vec%0d rdata", VECS[i].req, i), g_rd, VECS[i].exp);
         chk($sformatf("R%0d vec%0d pslverr", VECS[i].req, i), g_err, VECS[i].err);
         chk($sformatf("R10 vec%0d pready", i), g_rdy, 1);
      end

      // R2 outputs follow the control word
      chk("R2 cnt_en", cnt_en_o, 1);
      chk("R2 halt_dbg_en", halt_dbg_en_o, 1);
      chk("R2 scale_en", scale_en_o, 1);
      chk("R5 inc1 port", inc1_o, 32'h11);

      // R9 pending from the mismatch read, interrupt enabled
      chk("R9 irq raised", err_irq_o, 1);
      xfer(1'b1, 12'h008, 32'h0, 1'b0);
      chk("R9 write 0 keeps", err_irq_o, 1);
      xfer(1'b1, 12'h008, 32'h1, 1'b0);
      chk("R9 w1c clears", err_irq_o, 0);
      xfer(1'b0, 12'h008, 32'h0, 1'b0);
      chk("R9 pending read", g_rd, 0);

      // R6 mismatched write is dropped
      xfer(1'b1, 12'h000, 32'h0, 1'b1);
      chk("R6 write err", g_err, 1);
      xfer(1'b0, 12'h000, 32'h0, 1'b0);
      chk("R6 ctrl kept", g_rd, 32'h3F);
      xfer(1'b0, 12'h008, 32'h0, 1'b0);
      chk("R6 pending set", g_rd, 1);
      xfer(1'b1, 12'h008, 32'h1, 1'b0);

      // R7 decode miss
      xfer(1'b0, 12'h01C, 32'h0, 1'b0);
      chk("R7 miss rdata", g_rd, 0);
      chk("R7 miss no slverr", g_err, 0);
      xfer(1'b0, 12'h008, 32'h0, 1'b0);
      chk("R7 pending set", g_rd, 1);
      xfer(1'b1, 12'h008, 32'h1, 1'b0);
      xfer(1'b1, 12'h01C, 32'hFFFF_FFFF, 1'b0);
      chk("R7 miss write no load", g_lo | g_hi, 0);
      xfer(1'b0, 12'h000, 32'h0, 1'b0);
      chk("R7 ctrl untouched", g_rd, 32'h3F);
      xfer(1'b1, 12'h008, 32'h1, 1'b0);

      // R8 error response disabled
      xfer(1'b1, 12'h000, 32'h0000_002F, 1'b0);
      xfer(1'b0, 12'h004, 32'h0, 1'b1);
      chk("R8 slverr gated", g_err, 0);
      chk("R6 mismatch read zero", g_rd, 0);

      // R9 interrupt disabled while pending
      chk("R9 irq with enable", err_irq_o, 1);
      xfer(1'b1, 12'h000, 32'h0000_0027, 1'b0);
      chk("R9 irq gated", err_irq_o, 0);
      xfer(1'b0, 12'h008, 32'h0, 1'b0);
      chk("R9 still pending", g_rd, 1);

      // R4 count load strobes
      xfer(1'b1, 12'h014, 32'h0000_CAFE, 1'b0);
      chk("R4 load lo", {g_lo, g_hi}, 2'b10);
      chk("R4 load data", g_ld, 32'h0000_CAFE);
      xfer(1'b1, 12'h018, 32'h0000_BEEF, 1'b0);
      chk("R4 load hi", {g_lo, g_hi}, 2'b01);
      xfer(1'b1, 12'h014, 32'h1, 1'b1);
      chk("R4 mismatch no load", g_lo, 0);

      summary();
   end
endmodule